// File: doc/BRIEF.md
# Interval Alarm Timer

This block keeps a free-running base tick counter and shows software a slower interval count equal to that base count divided by four. Software reads the interval count through a one-cycle read strobe and arms an alarm by writing a 32-bit compare value. The alarm output is a level interrupt.

A compare write does not set up a plain equality match. The block turns the written value into an absolute deadline on the base counter. It takes the current base count and replaces its low 34 bits with the written value shifted up by two. If that deadline lies in the past, or sits closer to the present than a minimum lead, it is pushed out by one full 34-bit wrap. The interrupt rises once the base count has reached the deadline. It stays high until software writes the compare value again.

Top module: `interval_alarm`

## Requirements
- R1: The base counter is CNT_W (default 64) bits wide. Reset sets it to zero. It increments by one on every clock after reset and wraps naturally.
- R2: When `rd_en` is high in a cycle, `rd_data` holds bits [33:2] of the base count as it stood in that cycle (the interval count, base divided by four), starting from the following cycle. `rd_data` keeps its value while `rd_en` is low.
- R3: When `wr_en` is high in a cycle with base count B, the candidate deadline is B with bits [33:0] replaced by `{wr_data, 2'b00}`.
- R4: If the candidate is less than B + MIN_LEAD (default 1000), the deadline is the candidate plus 2^34. A candidate equal to B + MIN_LEAD is used unchanged.
- R5: Once a deadline D is armed, `irq` goes high in the cycle after the base count equals D. It then stays high for as long as no compare write occurs.
- R6: A compare write drives `irq` low from the next cycle. `irq` stays low until the new deadline is reached.
- R7: During and after reset, `irq` and `rd_data` are zero, and no alarm is armed until the first compare write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock; one base tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Compare write strobe |
| wr_data | input | 32 | Compare value in interval-count units |
| rd_en | input | 1 | Interval count read strobe |
| rd_data | output | 32 | Registered interval count from the last read |
| irq | output | 1 | Level alarm interrupt |

## Verification
A read strobe in the cycle whose base count is t is due in `rd_data` one cycle later, with the value t/4. A compare write is due one cycle later as a low `irq`. An armed deadline D shows as `irq` high in the cycle whose base count is D+1, and not yet in the cycle whose count is D. The bench keeps its own base count, which clears on the same edges as the design. It drives inputs and samples outputs on the falling clock edge. Each expected value is therefore tied to an exact base count, and the bench checks both the last cycle before the edge and the first cycle after it.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  // Base-tick bits per interval count step (divide by four).
  localparam int PRE_SH = 2;

  // Replace the low SW bits of base with val shifted up by PRE_SH.
  function automatic logic [63:0] splice64(input logic [63:0] base,
                                           input logic [31:0] val,
                                           input int sw);
    logic [63:0] mask;
    mask = (64'd1 << sw) - 64'd1;
    return (base & ~mask) | (({32'd0, val} << PRE_SH) & mask);
  endfunction
endpackage

// File: rtl/itmr_base_cnt.sv
module itmr_base_cnt #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] tick
);
  always_ff @(posedge clk) begin
    if (rst) tick <= '0;
    else     tick <= tick + 1'b1;
  end

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> tick == $past(tick) + 1'b1); // R1
endmodule

// File: rtl/itmr_deadline.sv
module itmr_deadline #(
  parameter int CNT_W    = 64,
  parameter int CMP_W    = 32,
  parameter int MIN_LEAD = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CMP_W-1:0] wr_data,
  input  logic [CNT_W-1:0] tick,
  output logic [CNT_W-1:0] deadline,
  output logic             armed
);
  import itmr_pkg::*;
  localparam int SPLICE_W = CMP_W + PRE_SH;
  localparam logic [CNT_W-1:0] LOW_MASK = (CNT_W'(1) << SPLICE_W) - CNT_W'(1);
  localparam logic [CNT_W-1:0] WRAP     = CNT_W'(1) << SPLICE_W;

  logic [CNT_W-1:0] cand, floor_v, next_dl;

  always_comb begin
    cand    = (tick & ~LOW_MASK) | ((CNT_W'(wr_data) << PRE_SH) & LOW_MASK);
    floor_v = tick + CNT_W'(MIN_LEAD);
    next_dl = (cand < floor_v) ? cand + WRAP : cand;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      deadline <= '0;
      armed    <= 1'b0;
    end else if (wr_en) begin
      deadline <= next_dl;
      armed    <= 1'b1;
    end
  end

  AST_LEAD_KEPT: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> deadline >= $past(tick) + CNT_W'(MIN_LEAD)); // R4
  AST_LOW_SPLICE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> deadline[SPLICE_W-1:PRE_SH] == $past(wr_data)); // R3
endmodule

// File: rtl/itmr_alarm.sv
module itmr_alarm #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             armed,
  input  logic [CNT_W-1:0] tick,
  input  logic [CNT_W-1:0] deadline,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (rst)                                irq <= 1'b0;
    else if (wr_en)                         irq <= 1'b0;
    else if (armed && (tick >= deadline))   irq <= 1'b1;
  end

  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !irq); // R6
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    irq && !wr_en |=> irq); // R5
  AST_IRQ_DUE: assert property (@(posedge clk) disable iff (rst)
    armed && (tick >= deadline) && !wr_en |=> irq); // R5
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (rst)
    !armed |-> !irq); // R7
endmodule

// File: rtl/interval_alarm.sv
module interval_alarm #(
  parameter int CNT_W    = 64,
  parameter int CMP_W    = 32,
  parameter int MIN_LEAD = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CMP_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [CMP_W-1:0] rd_data,
  output logic             irq
);
  import itmr_pkg::*;

  logic [CNT_W-1:0] tick, deadline;
  logic             armed;

  itmr_base_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick)
  );

  itmr_deadline #(.CNT_W(CNT_W), .CMP_W(CMP_W), .MIN_LEAD(MIN_LEAD)) u_dl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .tick(tick), .deadline(deadline), .armed(armed)
  );

  itmr_alarm #(.CNT_W(CNT_W)) u_alarm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .armed(armed),
    .tick(tick), .deadline(deadline), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= tick[PRE_SH +: CMP_W];
  end

  AST_RD_VALUE: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_data == $past(tick[PRE_SH +: CMP_W])); // R2
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data)); // R2
endmodule

// File: tb/interval_alarm_test.sv
module interval_alarm_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        irq;

  int errors = 0;
  int checks = 0;
  logic [63:0] t;      // bench-side base count
  logic [63:0] dl_exp; // expected deadline

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (rst) t <= '0;
    else     t <= t + 64'd1;
  end

  interval_alarm uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0d)", req, act, exp, t);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Write compare value; returns with inputs idle, one cycle after the write edge.
  task automatic do_write(input logic [31:0] v);
    logic [63:0] b, cand;
    wr_en = 1'b1; wr_data = v; b = t;
    @(negedge clk);
    wr_en = 1'b0;
    cand = {b[63:34], v, 2'b00};
    dl_exp = (cand < b + 64'd1000) ? cand + (64'd1 << 34) : cand;
  endtask

  task automatic wait_to(input logic [63:0] target);
    while (t < target) @(negedge clk);
  endtask

  task automatic align4();
    while (t[1:0] != 2'b00) @(negedge clk);
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk("R7 irq in reset", irq, 0);
    chk("R7 rd_data in reset", rd_data, 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    chk("R7 irq unarmed", irq, 0);
  endtask

  task automatic test_read();
    logic [63:0] tc;
    for (int i = 0; i < 3; i++) begin
      rd_en = 1'b1; tc = t;
      @(negedge clk);
      rd_en = 1'b0;
      chk("R1 R2 read value", rd_data, {32'd0, tc[33:2]});
      repeat (5 + i) @(negedge clk);
      chk("R2 read hold", rd_data, {32'd0, tc[33:2]});
    end
  endtask

  task automatic test_alarm();
    do_write(32'd1000);
    chk("R3 deadline splice", dl_exp, 64'd4000);
    chk("R6 irq low after write", irq, 0);
    wait_to(dl_exp);
    chk("R5 irq not before due", irq, 0);
    @(negedge clk);
    chk("R5 irq at due", irq, 1);
    repeat (50) @(negedge clk);
    chk("R5 irq sticky", irq, 1);
    do_write(32'd0);
    chk("R6 write clears irq", irq, 0);
    repeat (200) @(negedge clk);
    chk("R4 past value pushed, irq low", irq, 0);
  endtask

  task automatic test_lead_boundary();
    logic [63:0] b;
    align4();
    b = t;
    do_write(32'((b + 64'd1000) >> 2));
    chk("R4 exact lead not pushed", dl_exp, b + 64'd1000);
    wait_to(b + 64'd1000);
    chk("R4 not before exact lead", irq, 0);
    @(negedge clk);
    chk("R4 irq at exact lead", irq, 1);
    align4();
    b = t;
    do_write(32'((b + 64'd996) >> 2));
    chk("R6 clear on rewrite", irq, 0);
    wait_to(b + 64'd1500);
    chk("R4 short lead pushed one wrap", irq, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    test_reset();
    test_read();
    test_alarm();
    test_lead_boundary();
    test_read();
    finish_run();
  end
endmodule